// File: doc/BRIEF.md
# Iterative Right Shifter with Sticky Flag

This block is a multi-cycle right-shift execution unit for a small microcontroller datapath. A start strobe carries an 8-bit opcode, an operand, a count and a count-source select. The opcode picks one of two variants:

- a 32-bit arithmetic shift that copies the sign bit into the top position;
- an 8-bit logical shift that fills the top with zeros.

The unit then shifts the operand right by one bit on each clock until the remaining count is zero. While it runs it tracks the carry and sticky status bits. When the count is used up it presents the result with its carry, zero, negative, overflow and sticky flags, and pulses a completion strobe.

The surrounding sequencer holds the operand and count sources stable only for the start cycle. The unit captures everything it needs on that edge. A start that arrives while the unit is busy, or with an opcode it does not serve, is dropped. The overflow-trap status bit is not touched by this operation, so it passes from input to output unchanged.

Top module: `rshift_seq_unit`

## Requirements
- R1: Opcode 0x0E starts the 32-bit arithmetic shift and opcode 0x18 starts the 8-bit logical shift. A start pulse with any other opcode while idle is ignored: busy_o stays low and result_o and the flags keep their values.
- R2: With cnt_src_i = 0 the count is the immediate, and only cnt_i[3:0] is used (0 to 15). With cnt_src_i = 1 the count is the register value cnt_i[4:0] (0 to 31).
- R3: In the arithmetic mode, result_o is the 32-bit operand shifted right by the count, with every vacated top bit equal to the operand's bit 31.
- R4: In the logical byte mode, result_o[7:0] is opnd_i[7:0] shifted right by the count with zeros filling from the top, and result_o[31:8] reads 0.
- R5: carry_o holds the last bit shifted out of bit 0. With a count of zero the operand (zero-extended in byte mode) comes out unchanged and carry_o keeps its previous value.
- R6: sticky_o is cleared when an operation starts. It is 1 at completion exactly when some bit shifted out before the final shift was 1, that is, when a 1 sat in carry and a further shift then took place.
- R7: zero_o is 1 when result_o is zero. neg_o equals result_o[31] in the arithmetic mode and is 0 in the byte mode. ovf_o is always 0. trap_o equals trap_i.
- R8: busy_o rises on the clock after an accepted start and stays high up to and including the done cycle. done_o is high for exactly one cycle, N clock edges after the start edge, where N is the effective count (so a count of zero completes one cycle after the start). busy_o falls on the following edge.
- R9: A start pulse while busy_o is high is ignored, and the running operation finishes with its original result and flags.
- R10: After reset, busy_o, done_o, carry_o and sticky_o are 0, result_o is 0, and zero_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled with the other request inputs |
| opcode_i | input | 8 | Operation code: 0x0E arithmetic 32-bit, 0x18 logical 8-bit |
| cnt_src_i | input | 1 | Count source: 0 immediate (4 bits), 1 register (5 bits) |
| cnt_i | input | 5 | Shift count value |
| opnd_i | input | 32 | Operand to shift; byte mode uses bits 7:0 |
| trap_i | input | 1 | Overflow-trap status bit, carried through |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| ovf_o | output | 1 | Overflow flag, always 0 |
| trap_o | output | 1 | Overflow-trap status bit, equal to trap_i |
| sticky_o | output | 1 | Sticky flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the unit with its default parameters: a 32-bit wide operand, an 8-bit narrow operand, a 4-bit immediate count and a 5-bit register count. With these values the extreme cases can be driven directly:

- a register count of 31 against a negative operand;
- a byte shifted by 8 down to zero;
- an immediate of 0x1F that must be truncated to 15;
- zero counts in both modes.

The 5-bit register count also makes runs long enough that a start can be injected part-way through an operation.

// File: rtl/rsh_pkg.sv
package rsh_pkg;

   typedef enum logic [0:0] {
      MODE_BYTE_LOGIC = 1'b0,
      MODE_WIDE_ARITH = 1'b1
   } shmode_e;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } shstate_e;

   typedef struct packed {
      logic c;
      logic z;
      logic n;
      logic v;
      logic st;
   } shflags_t;

endpackage

// File: rtl/rsh_decode.sv
module rsh_decode
   import rsh_pkg::*;
#(
   parameter int          OPC_W     = 8,
   parameter logic [7:0]  OPC_ARITH = 8'h0E,
   parameter logic [7:0]  OPC_LOGIC = 8'h18,
   parameter int          IMM_BITS  = 4,
   parameter int          REG_BITS  = 5
) (
   input  logic [OPC_W-1:0]    opcode,
   input  logic                cnt_src,
   input  logic [REG_BITS-1:0] cnt_raw,
   output logic                op_valid,
   output shmode_e             op_mode,
   output logic [REG_BITS-1:0] cnt_eff
);

   localparam logic [OPC_W-1:0] ARITH_CODE = OPC_W'(OPC_ARITH);
   localparam logic [OPC_W-1:0] LOGIC_CODE = OPC_W'(OPC_LOGIC);

   logic hit_arith;
   logic hit_logic;

   always_comb begin
      hit_arith = (opcode == ARITH_CODE);
      hit_logic = (opcode == LOGIC_CODE);
      op_valid  = hit_arith | hit_logic;
      op_mode   = hit_arith ? MODE_WIDE_ARITH : MODE_BYTE_LOGIC;
   end

   generate
      if (IMM_BITS == REG_BITS) begin : g_same_width
         assign cnt_eff = cnt_raw;
      end else begin : g_trunc_imm
         logic [REG_BITS-1:0] imm_mask;
         always_comb begin
            imm_mask = '0;
            imm_mask[IMM_BITS-1:0] = '1;
            cnt_eff = cnt_src ? cnt_raw : (cnt_raw & imm_mask);
         end
      end
   endgenerate

endmodule

// File: rtl/rsh_ctrl.sv
module rsh_ctrl
   import rsh_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic [CNT_W-1:0] cnt_load,
   output logic             busy,
   output logic             step,
   output logic             fin
);

   shstate_e         state_q;
   logic [CNT_W-1:0] rem_q;
   logic             rem_zero;

   assign rem_zero = (rem_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rem_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (launch) begin
                  state_q <= ST_RUN;
                  rem_q   <= cnt_load;
               end
            end
            ST_RUN: begin
               if (rem_zero) begin
                  state_q <= ST_IDLE;
               end else begin
                  rem_q <= rem_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy = (state_q == ST_RUN);
      step = busy && !rem_zero;
      fin  = busy && rem_zero;
   end

endmodule

// File: rtl/rsh_shift_dp.sv
module rsh_shift_dp
   import rsh_pkg::*;
#(
   parameter int WIDE   = 32,
   parameter int NARROW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            step,
   input  shmode_e         mode_in,
   input  logic [WIDE-1:0] opnd_in,
   output logic [WIDE-1:0] data_q,
   output logic            carry_q,
   output logic            sticky_q,
   output shmode_e         mode_q
);

   logic [WIDE-1:0] data_nxt;
   logic [WIDE-1:0] load_val;
   logic            arith;
   logic            shifted_q;

   assign arith = (mode_q == MODE_WIDE_ARITH);

   // One-position shift network; each bit picks its source by position and mode
   genvar gi;
   generate
      for (gi = 0; gi < WIDE; gi++) begin : g_bit
         if (gi == WIDE - 1) begin : g_top
            assign data_nxt[gi] = arith ? data_q[gi] : 1'b0;
         end else if (gi >= NARROW - 1) begin : g_upper
            assign data_nxt[gi] = arith ? data_q[gi+1] : 1'b0;
         end else begin : g_lower
            assign data_nxt[gi] = data_q[gi+1];
         end
      end
   endgenerate

   always_comb begin
      load_val = '0;
      if (mode_in == MODE_WIDE_ARITH) begin
         load_val = opnd_in;
      end else begin
         load_val[NARROW-1:0] = opnd_in[NARROW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q    <= '0;
         carry_q   <= 1'b0;
         sticky_q  <= 1'b0;
         shifted_q <= 1'b0;
         mode_q    <= MODE_BYTE_LOGIC;
      end else if (load) begin
         data_q    <= load_val;
         sticky_q  <= 1'b0;
         shifted_q <= 1'b0;
         mode_q    <= mode_in;
      end else if (step) begin
         data_q    <= data_nxt;
         carry_q   <= data_q[0];
         sticky_q  <= sticky_q | (shifted_q & carry_q);
         shifted_q <= 1'b1;
      end
   end

endmodule

// File: rtl/rsh_flags.sv
module rsh_flags
   import rsh_pkg::*;
#(
   parameter int WIDE = 32
) (
   input  logic [WIDE-1:0] data,
   input  shmode_e         mode,
   input  logic            carry,
   input  logic            sticky,
   output shflags_t        flags
);

   always_comb begin
      flags.c  = carry;
      flags.z  = (data == '0);
      flags.n  = (mode == MODE_WIDE_ARITH) ? data[WIDE-1] : 1'b0;
      flags.v  = 1'b0;
      flags.st = sticky;
   end

endmodule

// File: rtl/rshift_seq_unit.sv
module rshift_seq_unit
   import rsh_pkg::*;
#(
   parameter int         WIDE      = 32,
   parameter int         NARROW    = 8,
   parameter int         OPC_W     = 8,
   parameter logic [7:0] OPC_ARITH = 8'h0E,
   parameter logic [7:0] OPC_LOGIC = 8'h18,
   parameter int         IMM_BITS  = 4,
   parameter int         REG_BITS  = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [OPC_W-1:0]    opcode_i,
   input  logic                cnt_src_i,
   input  logic [REG_BITS-1:0] cnt_i,
   input  logic [WIDE-1:0]     opnd_i,
   input  logic                trap_i,
   output logic [WIDE-1:0]     result_o,
   output logic                carry_o,
   output logic                zero_o,
   output logic                neg_o,
   output logic                ovf_o,
   output logic                trap_o,
   output logic                sticky_o,
   output logic                busy_o,
   output logic                done_o
);

   generate
      if (NARROW < 2 || NARROW >= WIDE) begin : g_bad_narrow
         $error("rshift_seq_unit: NARROW must be at least 2 and below WIDE");
      end
      if (IMM_BITS < 1 || IMM_BITS > REG_BITS) begin : g_bad_imm
         $error("rshift_seq_unit: IMM_BITS must be 1..REG_BITS");
      end
      if (OPC_W > 8 || OPC_ARITH == OPC_LOGIC) begin : g_bad_opc
         $error("rshift_seq_unit: opcodes must be distinct and OPC_W at most 8");
      end
   endgenerate

   logic                op_valid;
   shmode_e             op_mode;
   logic [REG_BITS-1:0] cnt_eff;
   logic                launch;
   logic                step;
   logic                fin;
   logic                busy;
   logic [WIDE-1:0]     data_q;
   logic                carry_q;
   logic                sticky_q;
   shmode_e             mode_q;
   shflags_t            flags;

   rsh_decode #(
      .OPC_W    (OPC_W),
      .OPC_ARITH(OPC_ARITH),
      .OPC_LOGIC(OPC_LOGIC),
      .IMM_BITS (IMM_BITS),
      .REG_BITS (REG_BITS)
   ) u_dec (
      .opcode  (opcode_i),
      .cnt_src (cnt_src_i),
      .cnt_raw (cnt_i),
      .op_valid(op_valid),
      .op_mode (op_mode),
      .cnt_eff (cnt_eff)
   );

   assign launch = start_i && op_valid && !busy;

   rsh_ctrl #(
      .CNT_W(REG_BITS)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (launch),
      .cnt_load(cnt_eff),
      .busy    (busy),
      .step    (step),
      .fin     (fin)
   );

   rsh_shift_dp #(
      .WIDE  (WIDE),
      .NARROW(NARROW)
   ) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (launch),
      .step    (step),
      .mode_in (op_mode),
      .opnd_in (opnd_i),
      .data_q  (data_q),
      .carry_q (carry_q),
      .sticky_q(sticky_q),
      .mode_q  (mode_q)
   );

   rsh_flags #(
      .WIDE(WIDE)
   ) u_flags (
      .data  (data_q),
      .mode  (mode_q),
      .carry (carry_q),
      .sticky(sticky_q),
      .flags (flags)
   );

   always_comb begin
      result_o = data_q;
      carry_o  = flags.c;
      zero_o   = flags.z;
      neg_o    = flags.n;
      ovf_o    = flags.v;
      sticky_o = flags.st;
      trap_o   = trap_i;
      busy_o   = busy;
      done_o   = fin;
   end

endmodule

// File: rtl/rsh_chk.sv
module rsh_chk
   import rsh_pkg::*;
#(
   parameter int         OPC_W     = 8,
   parameter logic [7:0] OPC_ARITH = 8'h0E,
   parameter logic [7:0] OPC_LOGIC = 8'h18
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [OPC_W-1:0] opcode_i,
   input logic             busy_o,
   input logic             done_o,
   input logic             neg_o,
   input logic             ovf_o,
   input logic             sticky_o,
   input shmode_e          mode_q
);

   logic code_ok;
   assign code_ok = (opcode_i == OPC_W'(OPC_ARITH)) || (opcode_i == OPC_W'(OPC_LOGIC));

   // R1
   launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && code_ok) |=> busy_o);

   // R1
   bad_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !code_ok) |=> !busy_o);

   // R6
   sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && code_ok) |=> !sticky_o);

   // R7
   byte_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && mode_q == MODE_BYTE_LOGIC) |-> !neg_o);

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_o);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);

   // R8
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(done_o));

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

endmodule

bind rshift_seq_unit rsh_chk #(
   .OPC_W    (OPC_W),
   .OPC_ARITH(OPC_ARITH),
   .OPC_LOGIC(OPC_LOGIC)
) u_rsh_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .opcode_i(opcode_i),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .neg_o   (neg_o),
   .ovf_o   (ovf_o),
   .sticky_o(sticky_o),
   .mode_q  (mode_q)
);

// File: tb/tb_rshift_seq_unit.sv
`timescale 1ns/1ps
module tb_rshift_seq_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  opcode_i = '0;
   logic        cnt_src_i = 1'b0;
   logic [4:0]  cnt_i = '0;
   logic [31:0] opnd_i = '0;
   logic        trap_i = 1'b0;
   logic [31:0] result_o;
   logic        carry_o, zero_o, neg_o, ovf_o, trap_o, sticky_o, busy_o, done_o;

   rshift_seq_unit dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
      .cnt_src_i(cnt_src_i), .cnt_i(cnt_i), .opnd_i(opnd_i), .trap_i(trap_i),
      .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o), .neg_o(neg_o),
      .ovf_o(ovf_o), .trap_o(trap_o), .sticky_o(sticky_o), .busy_o(busy_o),
      .done_o(done_o)
   );

   always #2.5 clk = ~clk;

   typedef struct {
      logic [31:0] res;
      logic        c;
      logic        z;
      logic        n;
      logic        st;
      int          lat;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails = 0;
   int   cyc = 0;
   int   start_cyc = 0;
   logic exp_carry = 1'b0;
   bit   finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   // Monitor: pops expected items when the design signals completion
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (q.size() == 0) begin
            chk(1'b0, "R8", "unexpected done", 32'(done_o), 32'h0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(result_o == e.res, "R3/R4", "result", result_o, e.res);
            chk(carry_o == e.c, "R5", "carry", 32'(carry_o), 32'(e.c));
            chk(sticky_o == e.st, "R6", "sticky", 32'(sticky_o), 32'(e.st));
            chk(zero_o == e.z && neg_o == e.n && ovf_o == 1'b0, "R7", "z/n/v",
                {29'b0, zero_o, neg_o, ovf_o}, {29'b0, e.z, e.n, 1'b0});
            chk((cyc - start_cyc) == e.lat, "R8", "latency",
                32'(cyc - start_cyc), 32'(e.lat));
         end
      end
   end

   task automatic model(input logic [7:0] opc, input logic src, input logic [4:0] cnt,
                        input logic [31:0] opnd);
      exp_t e;
      int   n;
      logic ar;
      logic [31:0] r;
      logic c;
      logic st;
      ar = (opc == 8'h0E);
      n  = src ? int'(cnt) : int'(cnt[3:0]);   // R2
      r  = ar ? opnd : {24'b0, opnd[7:0]};
      c  = exp_carry;
      st = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (i > 0 && c) st = 1'b1;
         c = r[0];
         r = ar ? {r[31], r[31:1]} : (r >> 1);
      end
      exp_carry = c;
      e.res = r; e.c = c; e.st = st; e.z = (r == 0);
      e.n = ar ? r[31] : 1'b0;
      e.lat = n;
      q.push_back(e);
   endtask

   // Driver: pushes the expected item, issues the start, optionally injects a
   // second start mid-run (R9), then waits for completion.
   task automatic run_op(input logic [7:0] opc, input logic src, input logic [4:0] cnt,
                         input logic [31:0] opnd, input bit inject);
      model(opc, src, cnt, opnd);
      @(negedge clk);
      opcode_i = opc; cnt_src_i = src; cnt_i = cnt; opnd_i = opnd; start_i = 1'b1;
      @(posedge clk);
      start_cyc = cyc + 1;
      @(negedge clk);
      start_i = 1'b0;
      opnd_i = 32'hDEAD_BEEF; cnt_i = 5'h1F;
      if (inject) begin
         @(negedge clk);
         opcode_i = 8'h18; cnt_src_i = 1'b1; cnt_i = 5'd1; opnd_i = 32'h0000_00FF;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (!done_o) @(negedge clk);
      @(negedge clk);
      chk(!busy_o && !done_o, "R8", "busy/done after completion",
          {30'b0, busy_o, done_o}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(!busy_o && !done_o && !carry_o && !sticky_o && zero_o && result_o == 0,
          "R10", "reset state",
          {26'b0, busy_o, done_o, carry_o, sticky_o, zero_o, |result_o}, 32'h2);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(8'h0E, 1'b1, 5'd4,  32'h8000_00F0, 0);   // R3 sign fill
      run_op(8'h18, 1'b0, 5'd3,  32'h0000_12B5, 0);   // R4 byte, R6 sticky set
      run_op(8'h18, 1'b0, 5'd1,  32'h0000_00FF, 0);   // R6 carry 1, no later shift
      run_op(8'h18, 1'b1, 5'd2,  32'h0000_00FF, 0);   // R6 sticky
      run_op(8'h0E, 1'b1, 5'd31, 32'h8000_0000, 0);   // R2 register count 31
      run_op(8'h0E, 1'b1, 5'd0,  32'h0000_0000, 0);   // R5 zero count, carry kept
      run_op(8'h0E, 1'b0, 5'h1F, 32'h7FFF_FFFF, 0);   // R2 immediate truncated to 15
      run_op(8'h18, 1'b1, 5'd8,  32'hFFFF_FFA5, 0);   // R4 byte to zero, R7 zero
      run_op(8'h0E, 1'b1, 5'd1,  32'h0000_0001, 0);   // R5 carry from bit 0
      run_op(8'h0E, 1'b1, 5'd12, 32'h1234_5678, 1);   // R9 start while busy
      run_op(8'h18, 1'b1, 5'd0,  32'h0000_0080, 0);   // R7 byte neg forced 0
      run_op(8'h0E, 1'b1, 5'd0,  32'h8000_0000, 0);   // R7 neg from bit 31

      // R1: unknown opcode while idle is ignored
      begin
         logic [31:0] keep_r;
         logic        keep_c;
         keep_r = result_o; keep_c = carry_o;
         @(negedge clk);
         opcode_i = 8'h55; cnt_src_i = 1'b1; cnt_i = 5'd3; opnd_i = 32'h0F0F_0F0F;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         chk(!busy_o, "R1", "busy after unknown opcode", 32'(busy_o), 32'h0);
         repeat (4) @(negedge clk);
         chk(result_o == keep_r && carry_o == keep_c && !done_o, "R1",
             "state after unknown opcode", result_o, keep_r);
      end

      // R7: trap bit passes through
      trap_i = 1'b1;
      #1;
      chk(trap_o == 1'b1, "R7", "trap high", 32'(trap_o), 32'h1);
      trap_i = 1'b0;
      #1;
      chk(trap_o == 1'b0, "R7", "trap low", 32'(trap_o), 32'h0);

      chk(q.size() == 0, "R8", "pending expected items", 32'(q.size()), 32'h0);
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule